// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

This block is a register-mapped general purpose I/O controller for up to 32 pins. Software sets the pin directions and the output values through registers. It reads back the synchronized pin state, which is valid whatever the direction of each pin. Every pin can request an interrupt in two ways. The first is a level source, recomputed live from the pin and a per-pin active-low select. The second is an edge source, which latches into an event register. A per-pin bit selects the rising or the falling edge, and software clears the event by writing 1 to it.

Each source has its own per-pin enable mask. The enabled requests of all pins are ORed into a single summary status bit. A top-level enable gates that bit onto one registered, active-high interrupt line.

Access is through a simple 32-bit port with a write strobe and a combinational read. Each pin input passes through two synchronizing flops before it reaches the data-in register and the edge detector.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` is all zero (all pins are inputs) and `irq` is 0.
- R2: The output-enable register (offset 0x48) drives `pin_oe`, and the data-out register (offset 0x44) drives `pin_out`. Writable per-pin registers read back only their low NPINS bits.
- R3: The data-in register (offset 0x40) shows each pin's value two clock edges after it is applied, whether the pin is an input or an output.
- R4: A level request is (data_in XOR level_polarity) AND level_mask, using offsets 0x40, 0x50 and 0x54. A polarity bit of 1 means the pin is active low. The request is not latched and drops when the pin returns to its inactive level.
- R5: An edge latches into the event register (offset 0x58). The edge-polarity register (offset 0x64) selects the edge: bit 0 means rising and bit 1 means falling. The opposite edge does not set the bit, and the bit stays set after the pin returns. An edge request is event AND edge_mask, with the edge mask at offset 0x5C.
- R6: Writing 1 to an event bit clears it. Event bits written with 0 keep their value.
- R7: When a detected edge and a write-1-to-clear hit the same event bit in the same cycle, the bit ends up set.
- R8: Bit 0 of the status register (offset 0x00) is 1 when any pin has an enabled level or edge request. The `irq` output equals that bit ANDed with bit 0 of the top mask register (offset 0x04), registered one cycle later.
- R9: Reads of unmapped offsets return zero. Writes to data-in (0x40) and status (0x00) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | NPINS | Pad input values |
| pin_out | output | NPINS | Output values for the pads |
| pin_oe | output | NPINS | Per-pin output enable, 1 = drive |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The bench puts a hardware edge and a clear write on the same event bit in the same cycle. A design that gives the clear priority would lose that edge. It checks that an edge of the unselected polarity leaves the event untouched, and that the event survives the pin returning. A design with the polarity inverted, or one that tracks the pin level, would show a wrong event value. It checks that a level request drops as soon as the pin returns, which catches a design that latches level requests. It measures the one-cycle delay from the top mask to `irq` and checks that writes to the read-only registers and to unmapped offsets change nothing.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [7:0] A_STAT = 8'h00, A_TMSK = 8'h04, A_DIN  = 8'h40,
                         A_DOUT = 8'h44, A_OE   = 8'h48, A_LPOL = 8'h50,
                         A_LMSK = 8'h54, A_EVT  = 8'h58, A_EMSK = 8'h5C,
                         A_EPOL = 8'h64;

  logic [NPINS-1:0] sync1, din, prev;
  logic [NPINS-1:0] dout, oe, lpol, lmsk, evt, emsk, epol;
  logic             tmsk;
  logic [NPINS-1:0] wbits, hit, clr, lvl_req, edg_req;
  logic             status;

  assign wbits   = reg_wdata[NPINS-1:0];
  assign hit     = (epol & prev & ~din) | (~epol & ~prev & din);
  assign clr     = (reg_we && reg_addr == A_EVT) ? wbits : '0;
  assign lvl_req = (din ^ lpol) & lmsk;
  assign edg_req = evt & emsk;
  assign status  = |(lvl_req | edg_req);
  assign pin_out = dout;
  assign pin_oe  = oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0; din <= '0; prev <= '0;
      dout <= '0; oe <= '0; lpol <= '0; lmsk <= '0;
      evt <= '0; emsk <= '0; epol <= '0; tmsk <= 1'b0;
      irq <= 1'b0;
    end else begin
      sync1 <= pin_in;
      din   <= sync1;
      prev  <= din;
      evt   <= (evt & ~clr) | hit;
      irq   <= status & tmsk;
      if (reg_we) begin
        case (reg_addr)
          A_TMSK: tmsk <= reg_wdata[0];
          A_DOUT: dout <= wbits;
          A_OE:   oe   <= wbits;
          A_LPOL: lpol <= wbits;
          A_LMSK: lmsk <= wbits;
          A_EMSK: emsk <= wbits;
          A_EPOL: epol <= wbits;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata[0] = status;
      A_TMSK: reg_rdata[0] = tmsk;
      A_DIN:  reg_rdata[NPINS-1:0] = din;
      A_DOUT: reg_rdata[NPINS-1:0] = dout;
      A_OE:   reg_rdata[NPINS-1:0] = oe;
      A_LPOL: reg_rdata[NPINS-1:0] = lpol;
      A_LMSK: reg_rdata[NPINS-1:0] = lmsk;
      A_EVT:  reg_rdata[NPINS-1:0] = evt;
      A_EMSK: reg_rdata[NPINS-1:0] = emsk;
      A_EPOL: reg_rdata[NPINS-1:0] = epol;
      default: ;
    endcase
  end
endmodule

module gpio_irq_ctrl_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [7:0]       reg_addr,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] evt,
  input logic [NPINS-1:0] din,
  input logic [NPINS-1:0] prev,
  input logic             tmsk,
  input logic             irq
);
  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tmsk) |-> !irq);
  // R6
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(evt) & ~evt)) |-> $past(reg_we && reg_addr == 8'h58));
  // R5
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & ~$past(evt))) |-> $past(din != prev));
  // R2
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(reg_we && reg_addr == 8'h48));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .pin_oe(pin_oe), .evt(evt), .din(din), .prev(prev), .tmsk(tmsk), .irq(irq)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int NPINS = 8;
  localparam int NVEC = 10;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h44, 32'h0000_00A5, 32'h0000_00A5},
    {8'h48, 32'hFFFF_FFFF, 32'h0000_00FF},
    {8'h50, 32'h1234_560F, 32'h0000_000F},
    {8'h54, 32'h0000_0000, 32'h0000_0000},
    {8'h5C, 32'hFFFF_FF3C, 32'h0000_003C},
    {8'h64, 32'h0000_00F0, 32'h0000_00F0},
    {8'h04, 32'hFFFF_FFFE, 32'h0000_0000},
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic [NPINS-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NPINS)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pin_oe", 32'(pin_oe), 32'd0);
    for (int a = 0; a < 8'h70; a += 4) begin
      rd(8'(a), rv);
      chk("R1 register", rv, 32'd0);
    end

    // R2 R9 vector walk: write then read back
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], rv);
      chk(i < 7 ? "R2 readback" : "R9 ignored", rv, VEC[i][31:0]);
    end
    chk("R2 pin_oe", 32'(pin_oe), 32'h0000_00FF);
    chk("R2 pin_out", 32'(pin_out), 32'h0000_00A5);
    wr(8'h50, 0); wr(8'h5C, 0); wr(8'h64, 0);

    // R3 data in with pins as outputs, two-edge latency
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); rd(8'h40, rv); chk("R3 after one edge", rv, 32'h00);
    @(negedge clk); rd(8'h40, rv); chk("R3 after two edges", rv, 32'h5A);
    wr(8'h48, 0);
    @(negedge clk); pin_in = 8'h00; idle(3);
    rd(8'h40, rv); chk("R3 input dir", rv, 32'h00);
    wr(8'h58, 32'hFF);

    // R4 level, active high on pin 0
    wr(8'h04, 1); wr(8'h54, 32'h01);
    @(negedge clk); pin_in = 8'h01; idle(4);
    chk("R4 level high irq", {31'd0, irq}, 32'd1);
    @(negedge clk); pin_in = 8'h00; idle(4);
    chk("R4 level not latched", {31'd0, irq}, 32'd0);
    // R4 active low on pin 1
    wr(8'h50, 32'h02); wr(8'h54, 32'h02); idle(3);
    chk("R4 active low", {31'd0, irq}, 32'd1);
    wr(8'h54, 0); wr(8'h50, 0); idle(3);
    chk("R4 masked", {31'd0, irq}, 32'd0);

    // R5 rising on pin 2, falling on pin 3
    wr(8'h58, 32'hFF);
    wr(8'h5C, 32'h04); wr(8'h64, 32'h08);
    @(negedge clk); pin_in = 8'h0C; idle(4);
    rd(8'h58, rv); chk("R5 rise sets, rise on falling pin ignored", rv, 32'h04);
    chk("R5 edge irq", {31'd0, irq}, 32'd1);
    @(negedge clk); pin_in = 8'h00; idle(4);
    rd(8'h58, rv); chk("R5 falling sets, rising stays", rv, 32'h0C);

    // R6 write-1-to-clear
    wr(8'h58, 32'h04); rd(8'h58, rv); chk("R6 partial clear", rv, 32'h08);
    idle(2); chk("R6 irq drops", {31'd0, irq}, 32'd0);
    wr(8'h58, 32'h08); rd(8'h58, rv); chk("R6 full clear", rv, 32'h00);

    // R8 status vs top mask and registered irq
    wr(8'h04, 0);
    @(negedge clk); pin_in = 8'h04; idle(4);
    rd(8'h00, rv); chk("R8 status", rv, 32'd1);
    chk("R8 masked irq", {31'd0, irq}, 32'd0);
    wr(8'h04, 1);
    chk("R8 irq one cycle late", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq asserted", {31'd0, irq}, 32'd1);
    wr(8'h58, 32'hFF);
    rd(8'h00, rv); chk("R8 status cleared", rv, 32'd0);

    // R7 edge and clear in the same cycle
    @(negedge clk); pin_in = 8'h00; idle(4);
    wr(8'h58, 32'hFF);
    @(negedge clk); pin_in = 8'h04;
    @(negedge clk);
    wr(8'h58, 32'h04);
    rd(8'h58, rv); chk("R7 edge wins over clear", rv, 32'h04);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule